// File: doc/BRIEF.md
# USB Device Bus-State Monitor

This block watches the line state of a full-speed USB device port after the line state has been synchronised. It tracks three bus conditions and gives each one a sticky status flag. The first is a long idle period, which puts the bus into suspend. The second is a sustained single-ended zero, which is a bus reset. The third is a K state that arrives while the bus is suspended, which is a host-driven resume.

The block can also wake the host itself. It drives a K state upstream for a fixed number of microsecond ticks. It does this only when software asks and the bus has already been suspended long enough.

The block also produces several control outputs:
- It drives the attach pull-up onto D+ for a full-speed device or onto D- for a low-speed device.
- It keeps a pull-during-reset setting that only a power-on reset clears. While the device is held in reset, this setting keeps the pull-up on.
- It raises a NACK-all indication for the transaction layer. SETUP packets are exempt from it.

All timing runs on two references. The `us_tick` strobe (one clock wide, once per microsecond) times idle, suspend and drive periods. The bus-reset length is counted in clock cycles. The line code on `line_i` is 2'b00 for SE0, 2'b01 for J, 2'b10 for K and 2'b11 for SE1.

Top module: `usb_bus_monitor`

## Requirements
- R1: While `por_n` or `rst_n` is low, and in the cycle after both rise, `status` is 0 and `drive_k` is 0.
- R2: Suppose the bus is neither suspended nor driving. If J is held for IDLE_TICKS ticks in a row, the bus becomes suspended and the suspend flag (`status[1]`) is set. Any code other than J restarts the count.
- R3: If SE0 is held for SE0_CYCLES consecutive clocks while not driving, the bus-reset flag (`status[0]`) is set and the suspended condition is cleared.
- R4: A K code seen while suspended sets the resume flag (`status[2]`) and ends the suspended condition.
- R5: A `wake_req` strobe starts an upstream resume only after the bus has been suspended for at least WAKE_TICKS ticks. An earlier strobe has no effect.
- R6: An upstream resume raises `drive_k` for DRIVE_TICKS ticks and sets the upstream-resume flag (`status[3]`). While `drive_k` is high, line codes are ignored. Afterwards the bus counts as active.
- R7: The flags in `status[3:0]` are sticky. Each one is cleared by a one on the matching bit of `flag_clr`. If a flag is set and cleared in the same cycle, the set wins. `status[7:4]` always reads 0.
- R8: The pull-up enable goes to `pu_dp` when `low_speed` is 0 and to `pu_dm` when `low_speed` is 1. With both resets high, the enable follows `attach`.
- R9: The pull-during-reset bit is loaded by `pullrst_we`/`pullrst_wd` and read on `pullrst_o`. While `rst_n` is low, the pull-up enable equals this bit. Only `por_n` clears it.
- R10: `nack_all` is high exactly when `gnack` is high and `pkt_setup` is low.
- R11: A low `rst_n` clears all flags and the monitoring state but leaves `pullrst_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_n | input | 1 | Device reset, active low |
| line_i | input | 2 | Synchronised line code |
| us_tick | input | 1 | One-cycle microsecond strobe |
| attach | input | 1 | Attach request |
| low_speed | input | 1 | 1 selects low-speed pull-up on D- |
| wake_req | input | 1 | Remote-wakeup request strobe |
| gnack | input | 1 | Global NACK enable |
| pkt_setup | input | 1 | Current token is SETUP |
| pullrst_we | input | 1 | Write strobe for pull-during-reset bit |
| pullrst_wd | input | 1 | Write data for pull-during-reset bit |
| flag_clr | input | 4 | Write-one-to-clear strobes for flags |
| status | output | 8 | Flags: [0] bus reset, [1] suspend, [2] resume, [3] upstream resume |
| pullrst_o | output | 1 | Current pull-during-reset bit |
| pu_dp | output | 1 | D+ pull-up enable |
| pu_dm | output | 1 | D- pull-up enable |
| drive_k | output | 1 | Drive K state upstream |
| nack_all | output | 1 | NACK all non-SETUP transactions |

## Verification
The hardest state to reach from the ports is an accepted remote wakeup. It needs an unbroken suspend: IDLE_TICKS of pure J first, then WAKE_TICKS more ticks with no K and no SE0. Only then can a wakeup strobe take effect.

The bench shortens every time constant through parameters and supplies the tick from a divider. It first sends a wakeup strobe too early and checks that nothing happens. It then waits out the remaining time and sends a second strobe. While `drive_k` is high, the bench drives K on the line itself, so it can confirm that the block's own resume is not mistaken for a downstream resume.

// File: rtl/usb_mon_pkg.sv
package usb_mon_pkg;
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    BS_ACTIVE = 2'd0,
    BS_SUSP   = 2'd1,
    BS_DRIVE  = 2'd2
  } bus_st_e;

  localparam int NFLAG = 4;

  // saturating increment: advance only when adv is high and below lim
  function automatic int unsigned sat_step(int unsigned cur, int unsigned lim, logic adv);
    if (adv && cur < lim) return cur + 1;
    return cur;
  endfunction

  // counter width able to hold the value lim
  function automatic int unsigned cnt_w(int unsigned lim);
    if (lim < 2) return 1;
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/usb_line_timer.sv
module usb_line_timer
  import usb_mon_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = 3000,
  parameter int unsigned SE0_CYCLES = 120
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_e line,
  input  logic  tick,
  input  logic  hold,
  output logic  idle_hit,
  output logic  se0_hit
);
  localparam int unsigned IW = cnt_w(IDLE_TICKS);
  localparam int unsigned SW = cnt_w(SE0_CYCLES);

  logic [IW-1:0] idle_q;
  logic [SW-1:0] se0_q;
  logic is_j, is_se0;

  assign is_j   = (line == LN_J)   && !hold;
  assign is_se0 = (line == LN_SE0) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      se0_q  <= '0;
    end else begin
      idle_q <= is_j   ? IW'(sat_step(32'(idle_q), IDLE_TICKS, tick)) : '0;
      se0_q  <= is_se0 ? SW'(sat_step(32'(se0_q), SE0_CYCLES, 1'b1)) : '0;
    end
  end

  assign idle_hit = is_j && tick && (32'(idle_q) == IDLE_TICKS - 1);
  assign se0_hit  = is_se0 && (32'(se0_q) == SE0_CYCLES - 1);
endmodule

// File: rtl/usb_susp_wake.sv
module usb_susp_wake
  import usb_mon_pkg::*;
#(
  parameter int unsigned WAKE_TICKS  = 5000,
  parameter int unsigned DRIVE_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic idle_hit,
  input  logic se0_hit,
  input  logic line_k,
  input  logic wake_req,
  output logic suspended,
  output logic driving,
  output logic ev_susp,
  output logic ev_res,
  output logic ev_wake
);
  localparam int unsigned WW = cnt_w(WAKE_TICKS);
  localparam int unsigned DW = cnt_w(DRIVE_TICKS);

  bus_st_e st_q, st_d;
  logic [WW-1:0] sus_q;
  logic [DW-1:0] drv_q;
  logic wake_ok, drv_end;

  assign suspended = (st_q == BS_SUSP);
  assign driving   = (st_q == BS_DRIVE);
  assign wake_ok   = 32'(sus_q) >= WAKE_TICKS;
  assign drv_end   = driving && tick && (32'(drv_q) == DRIVE_TICKS - 1);

  assign ev_susp = (st_q == BS_ACTIVE) && idle_hit;
  assign ev_res  = suspended && line_k;
  assign ev_wake = suspended && !se0_hit && !line_k && wake_req && wake_ok;

  always_comb begin
    st_d = st_q;
    case (st_q)
      BS_ACTIVE: if (ev_susp) st_d = BS_SUSP;
      BS_SUSP: begin
        if (se0_hit || ev_res) st_d = BS_ACTIVE;
        else if (ev_wake)      st_d = BS_DRIVE;
      end
      BS_DRIVE: if (drv_end) st_d = BS_ACTIVE;
      default: st_d = BS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_ACTIVE;
      sus_q <= '0;
      drv_q <= '0;
    end else begin
      st_q  <= st_d;
      sus_q <= suspended ? WW'(sat_step(32'(sus_q), WAKE_TICKS, tick)) : '0;
      drv_q <= driving ? DW'(sat_step(32'(drv_q), DRIVE_TICKS, tick)) : '0;
    end
  end
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_bus_monitor.sv
module usb_bus_monitor
  import usb_mon_pkg::*;
#(
  parameter int unsigned IDLE_TICKS  = 3000,
  parameter int unsigned SE0_CYCLES  = 120,
  parameter int unsigned WAKE_TICKS  = 5000,
  parameter int unsigned DRIVE_TICKS = 10000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic [1:0] line_i,
  input  logic       us_tick,
  input  logic       attach,
  input  logic       low_speed,
  input  logic       wake_req,
  input  logic       gnack,
  input  logic       pkt_setup,
  input  logic       pullrst_we,
  input  logic       pullrst_wd,
  input  logic [3:0] flag_clr,
  output logic [7:0] status,
  output logic       pullrst_o,
  output logic       pu_dp,
  output logic       pu_dm,
  output logic       drive_k,
  output logic       nack_all
);
  logic mon_rst_n;
  line_e line;
  logic idle_hit, ev_rst, suspended, driving;
  logic ev_susp, ev_res, ev_wake;
  logic [NFLAG-1:0] flags, flag_set;
  logic pr_q, pu_en;

  assign mon_rst_n = por_n & rst_n;
  assign line      = line_e'(line_i);

  usb_line_timer #(
    .IDLE_TICKS(IDLE_TICKS),
    .SE0_CYCLES(SE0_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (mon_rst_n),
    .line    (line),
    .tick    (us_tick),
    .hold    (driving),
    .idle_hit(idle_hit),
    .se0_hit (ev_rst)
  );

  usb_susp_wake #(
    .WAKE_TICKS (WAKE_TICKS),
    .DRIVE_TICKS(DRIVE_TICKS)
  ) u_wake (
    .clk      (clk),
    .rst_n    (mon_rst_n),
    .tick     (us_tick),
    .idle_hit (idle_hit),
    .se0_hit  (ev_rst),
    .line_k   (line == LN_K),
    .wake_req (wake_req),
    .suspended(suspended),
    .driving  (driving),
    .ev_susp  (ev_susp),
    .ev_res   (ev_res),
    .ev_wake  (ev_wake)
  );

  assign flag_set = {ev_wake, ev_res, ev_susp, ev_rst};

  usb_flag_bank #(.N(NFLAG)) u_flags (
    .clk  (clk),
    .rst_n(mon_rst_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .q    (flags)
  );

  // pull-during-reset bit: only power-on reset clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          pr_q <= 1'b0;
    else if (pullrst_we) pr_q <= pullrst_wd;
  end

  assign pu_en     = rst_n ? attach : pr_q;
  assign pu_dp     = por_n && pu_en && !low_speed;
  assign pu_dm     = por_n && pu_en && low_speed;
  assign pullrst_o = pr_q;
  assign status    = {{(8 - NFLAG){1'b0}}, flags};
  assign drive_k   = driving;
  assign nack_all  = gnack && !pkt_setup;
endmodule

// File: rtl/usb_bus_monitor_chk.sv
module usb_bus_monitor_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       drive_k,
  input logic       suspended,
  input logic       ev_susp,
  input logic       ev_rst,
  input logic       ev_res,
  input logic       pu_dp,
  input logic       pu_dm,
  input logic       pkt_setup,
  input logic       nack_all
);
  // R2
  susp_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ev_susp |=> status[1]);
  // R3
  busrst_clears_susp_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ev_rst |=> (status[0] && !suspended));
  // R4
  resume_exit_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ev_res |=> (status[2] && !suspended));
  // R5
  wake_from_susp_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(drive_k) |-> $past(suspended));
  // R6
  ures_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(drive_k) |-> status[3]);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    status[7:4] == 4'b0);
  // R8
  one_pullup_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !(pu_dp && pu_dm));
  // R10
  setup_exempt_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    pkt_setup |-> !nack_all);
endmodule

bind usb_bus_monitor usb_bus_monitor_chk u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .rst_n    (rst_n),
  .status   (status),
  .drive_k  (drive_k),
  .suspended(suspended),
  .ev_susp  (ev_susp),
  .ev_rst   (ev_rst),
  .ev_res   (ev_res),
  .pu_dp    (pu_dp),
  .pu_dm    (pu_dm),
  .pkt_setup(pkt_setup),
  .nack_all (nack_all)
);

// File: tb/sim_usb_bus_monitor.sv
`timescale 1ns/100ps
module sim_usb_bus_monitor;
  localparam int IDLE = 20, SE0N = 6, WAKE = 30, DRV = 12, TDIV = 4;

  logic clk = 0;
  logic por_n = 0, rst_n = 0;
  logic [1:0] line_i = 2'b01;
  logic us_tick = 0, attach = 0, low_speed = 0, wake_req = 0;
  logic gnack = 0, pkt_setup = 0, pullrst_we = 0, pullrst_wd = 0;
  logic [3:0] flag_clr = 0;
  logic [7:0] status;
  logic pullrst_o, pu_dp, pu_dm, drive_k, nack_all;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_bus_monitor #(.IDLE_TICKS(IDLE), .SE0_CYCLES(SE0N),
                    .WAKE_TICKS(WAKE), .DRIVE_TICKS(DRV)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .line_i(line_i), .us_tick(us_tick),
    .attach(attach), .low_speed(low_speed), .wake_req(wake_req), .gnack(gnack),
    .pkt_setup(pkt_setup), .pullrst_we(pullrst_we), .pullrst_wd(pullrst_wd),
    .flag_clr(flag_clr), .status(status), .pullrst_o(pullrst_o), .pu_dp(pu_dp),
    .pu_dm(pu_dm), .drive_k(drive_k), .nack_all(nack_all));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_idle = 0, m_se0 = 0, m_scnt = 0, m_dcnt = 0;
  bit m_susp = 0, m_drv = 0, m_pr = 0;
  bit [3:0] m_f = 0;

  always @(posedge clk) begin
    bit j, k, s0, e_rst, e_susp, e_res, e_wake, e_end;
    if (!por_n) m_pr = 0;
    else if (pullrst_we) m_pr = pullrst_wd;
    if (!por_n || !rst_n) begin
      m_idle = 0; m_se0 = 0; m_scnt = 0; m_dcnt = 0;
      m_susp = 0; m_drv = 0; m_f = 0;
    end else begin
      j = line_i == 2'b01; k = line_i == 2'b10; s0 = line_i == 2'b00;
      e_rst  = s0 && !m_drv && m_se0 == SE0N - 1;
      e_susp = !m_susp && !m_drv && j && us_tick && m_idle == IDLE - 1;
      e_res  = m_susp && k;
      e_wake = m_susp && wake_req && m_scnt >= WAKE && !e_rst && !e_res;
      e_end  = m_drv && us_tick && m_dcnt == DRV - 1;
      if (!j || m_drv) m_idle = 0;
      else if (us_tick && m_idle < IDLE) m_idle++;
      if (s0 && !m_drv) m_se0 = (m_se0 < SE0N) ? m_se0 + 1 : m_se0;
      else m_se0 = 0;
      if (!m_susp) m_scnt = 0;
      else if (us_tick && m_scnt < WAKE) m_scnt++;
      if (!m_drv) m_dcnt = 0;
      else if (us_tick && m_dcnt < DRV) m_dcnt++;
      if (m_susp) begin
        if (e_rst || e_res) m_susp = 0;
        else if (e_wake) begin m_susp = 0; m_drv = 1; end
      end else if (m_drv) begin
        if (e_end) m_drv = 0;
      end else if (e_susp) m_susp = 1;
      for (int i = 0; i < 4; i++) begin
        bit s;
        s = (i == 0) ? e_rst : (i == 1) ? e_susp : (i == 2) ? e_res : e_wake;
        if (s) m_f[i] = 1;
        else if (flag_clr[i]) m_f[i] = 0;
      end
    end
  end

  // every-cycle comparison against the model
  initial begin
    forever begin
      bit pu;
      @(posedge clk); #1;
      if (done) break;
      pu = !por_n ? 0 : (!rst_n ? m_pr : attach);
      chk("R3 busrst flag", status[0], m_f[0]);
      chk("R2 suspend flag", status[1], m_f[1]);
      chk("R4 resume flag", status[2], m_f[2]);
      chk("R6 upstream resume flag", status[3], m_f[3]);
      chk("R7 reserved bits", status[7:4], 0);
      chk("R5 drive_k", drive_k, m_drv);
      chk("R8 pu_dp", pu_dp, pu && !low_speed);
      chk("R8 pu_dm", pu_dm, pu && low_speed);
      chk("R9 pullrst_o", pullrst_o, m_pr);
      chk("R10 nack_all", nack_all, gnack && !pkt_setup);
    end
  end

  // microsecond tick divider
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      us_tick = (c % TDIV) == TDIV - 1;
      c++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    cyc(n * TDIV);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    cyc(200000 / 2);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      report();
      $finish;
    end
  end

  initial begin
    cyc(5);
    chk("R1 reset status", status, 0);
    chk("R1 reset drive_k", drive_k, 0);
    por_n = 1; rst_n = 1;
    cyc(1);
    chk("R1 status after release", status, 0);
    // pull-up selection
    attach = 1; cyc(1);
    chk("R8 full speed dp", pu_dp, 1);
    low_speed = 1; cyc(1);
    chk("R8 low speed dm", pu_dm, 1);
    chk("R8 low speed dp off", pu_dp, 0);
    low_speed = 0; attach = 0; cyc(1);
    chk("R8 detached", pu_dp, 0);
    attach = 1;
    // global nack
    gnack = 1; cyc(1);
    chk("R10 nack", nack_all, 1);
    pkt_setup = 1; cyc(1);
    chk("R10 setup exempt", nack_all, 0);
    pkt_setup = 0; gnack = 0;
    // idle broken by K restarts the suspend count
    line_i = 2'b01; ticks(IDLE - 5);
    line_i = 2'b10; cyc(2);
    line_i = 2'b01; ticks(IDLE - 5);
    chk("R2 no suspend after broken idle", status[1], 0);
    ticks(10);
    chk("R2 suspend set", status[1], 1);
    flag_clr = 4'b0010; cyc(1); flag_clr = 0; cyc(1);
    chk("R7 w1c suspend", status[1], 0);
    // downstream resume
    line_i = 2'b10; cyc(3);
    chk("R4 resume flag", status[2], 1);
    line_i = 2'b01;
    ticks(IDLE + 2);
    // early wake request ignored
    ticks(10);
    wake_req = 1; cyc(1); wake_req = 0; cyc(2);
    chk("R5 early wake ignored", drive_k, 0);
    flag_clr = 4'b1111; cyc(1); flag_clr = 0;
    ticks(WAKE);
    wake_req = 1; cyc(1); wake_req = 0;
    chk("R6 drive started", drive_k, 1);
    chk("R6 uresume flag", status[3], 1);
    line_i = 2'b10;
    ticks(DRV + 1);
    line_i = 2'b01; cyc(2);
    chk("R6 drive ended", drive_k, 0);
    chk("R6 own K not a resume", status[2], 0);
    // short then long SE0
    line_i = 2'b00; cyc(SE0N - 2); line_i = 2'b01; cyc(2);
    chk("R3 short SE0 ignored", status[0], 0);
    ticks(IDLE + 2);
    chk("R2 suspended before reset", status[1], 1);
    line_i = 2'b00; cyc(SE0N + 3); line_i = 2'b01; cyc(1);
    chk("R3 bus reset flag", status[0], 1);
    flag_clr = 4'b0100; cyc(1); flag_clr = 0;
    line_i = 2'b10; cyc(2); line_i = 2'b01; cyc(1);
    chk("R3 reset left suspend", status[2], 0);
    // pull during reset
    pullrst_we = 1; pullrst_wd = 1; cyc(1); pullrst_we = 0;
    attach = 0; rst_n = 0; cyc(2);
    chk("R9 pull-up held in reset", pu_dp, 1);
    chk("R11 flags cleared", status, 0);
    rst_n = 1; cyc(2);
    chk("R11 pullrst kept", pullrst_o, 1);
    por_n = 0; cyc(2);
    chk("R9 por clears pullrst", pullrst_o, 0);
    por_n = 1; cyc(3);
    done = 1;
    report();
    $finish;
  end
endmodule